// File: doc/BRIEF.md
# Prioritized Interrupt Level Dispatcher

This block decides, one request at a time, whether a pending interrupt level is taken. If it is, the block commits the resulting processor-state changes on a single clock edge. The core presents four things: a pending level with a request strobe, its current status word, the raised and enabled interrupt lines, and the program counter and vector base in use. When the level passes the acceptance test, the block produces the redirected program counter and the new status word. It also records the return state in its banks of saved-PC and saved-status registers and emits a one-cycle taken pulse.

The highest levels each own a vector and a pair of save registers. Level 1 works differently: it is folded into the general exception path. It writes a fixed cause code and is dispatched as a kernel, user or double exception, chosen from two status bits. The core feeds the status word back from its own register file, so the block keeps only the state it writes.

The status word has a fixed layout that the core also decodes:
- bits [3:0] hold the current interrupt level;
- bit 4 is the exception-mode flag;
- bit 5 is the user-mode flag.

Interrupt line b belongs to level (b mod NLEVEL)+1.

Top module: `irq_dispatch`

## Requirements
- R1: A request is accepted only when irq_pending is 1, irq_level is greater than ps_in[3:0], irq_level is at most NLEVEL, and at least one interrupt line b with (b mod NLEVEL)+1 equal to irq_level is set in both int_set and int_enable. Levels 0 and above NLEVEL are never accepted.
- R2: taken is 1 for exactly the cycle after the clock edge that sampled an accepted request, and all outputs change on that same edge. Without an accepted request, next_pc, next_ps, exc_class, exc_cause and every saved register keep their values.
- R3: For an accepted level L greater than 1:
  - save slot L of epc_flat receives cur_pc, and save slot L of eps_flat receives ps_in;
  - next_ps equals ps_in with bits [3:0] replaced by L and bit 4 set;
  - exc_class is 0 (high-level interrupt).
- R4: For an accepted level L greater than 1, the default target is DEF_VECBASE + L*LVL_STRIDE. It is then relocated by R8.
- R5: For an accepted level 1, exc_cause becomes 4 and next_ps equals ps_in with bit 4 set.
- R6: For an accepted level 1 with ps_in[4] set, exc_class is 3 (double). cur_pc goes to depc when HAS_DEPC is 1, and otherwise to save slot 1 of epc_flat.
- R7: For an accepted level 1 with ps_in[4] clear, cur_pc goes to save slot 1 of epc_flat. exc_class is 2 (user) when ps_in[5] is set and 1 (kernel) otherwise. The class default targets are KERN_VEC, USER_VEC and DBL_VEC.
- R8: With RELOC_EN set, a nonzero default target D becomes D - DEF_VECBASE + vecbase (modulo 2^32). With RELOC_EN clear, it is D unchanged.
- R9: When the default target is zero, next_pc becomes cur_pc.
- R10: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pending | input | 1 | A pending level is presented this cycle |
| irq_level | input | 4 | Pending interrupt level |
| ps_in | input | 32 | Current status word |
| int_set | input | 32 | Raised interrupt lines |
| int_enable | input | 32 | Enabled interrupt lines |
| cur_pc | input | 32 | Program counter at the interrupt point |
| vecbase | input | 32 | Vector base register |
| taken | output | 1 | One-cycle pulse: an interrupt was taken |
| next_pc | output | 32 | Redirected program counter |
| next_ps | output | 32 | Updated status word |
| exc_class | output | 2 | 0 high-level, 1 kernel, 2 user, 3 double |
| exc_cause | output | 6 | Exception cause (4 for a level-1 interrupt) |
| epc_flat | output | 224 | Saved PCs, slot L at bits [32L-1:32L-32] |
| eps_flat | output | 224 | Saved status words, same slots (slot 1 is zero) |
| depc | output | 32 | Double-exception saved PC |

## Verification
The bench builds two instances with seven levels and drives them with the same stimulus.
- u0 uses the default parameters: a double-exception save register, vector relocation, and a nonzero double vector. It exercises the relocation arithmetic and the separate double save.
- u1 has no double-exception save register, no relocation and a zero double vector. It brings within reach the fallback of the double save into slot 1 and the rule that a zero vector leaves the PC unchanged.

Random levels from 0 to 8, together with sparse enable masks, hit both the acceptance and the rejection paths of each instance.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;
   localparam int PS_LVL_W    = 4;
   localparam int PS_EXCM_BIT = 4;
   localparam int PS_UM_BIT   = 5;
   localparam int CAUSE_W     = 6;
   localparam logic [CAUSE_W-1:0] CAUSE_LVL1_IRQ = 6'd4;

   typedef enum logic [1:0] {
      CLS_HILVL  = 2'd0,
      CLS_KERNEL = 2'd1,
      CLS_USER   = 2'd2,
      CLS_DOUBLE = 2'd3
   } exc_cls_e;
endpackage

// File: rtl/irq_accept.sv
module irq_accept #(
   parameter int NLEVEL = 7,
   parameter int INT_W  = 32,
   parameter int LVL_W  = 4
) (
   input  logic              pending,
   input  logic [LVL_W-1:0]  lvl,
   input  logic [LVL_W-1:0]  cur_lvl,
   input  logic [INT_W-1:0]  intset,
   input  logic [INT_W-1:0]  intenable,
   output logic [NLEVEL:1]   lvl_sel,
   output logic              accept
);
   logic [NLEVEL:1] lvl_hit;
   logic [INT_W-1:0] live;

   assign live = intset & intenable;

   for (genvar i = 1; i <= NLEVEL; i++) begin : g_lvl
      logic [INT_W-1:0] mask;
      for (genvar b = 0; b < INT_W; b++) begin : g_bit
         assign mask[b] = (((b % NLEVEL) + 1) == i);
      end
      assign lvl_sel[i] = (lvl == LVL_W'(i));
      assign lvl_hit[i] = |(mask & live);
   end

   assign accept = pending && (lvl > cur_lvl) && (|(lvl_sel & lvl_hit));
endmodule

// File: rtl/irq_vector.sv
module irq_vector
   import irq_disp_pkg::*;
#(
   parameter int                NLEVEL      = 7,
   parameter int                ADDR_W      = 32,
   parameter bit                RELOC_EN    = 1'b1,
   parameter logic [ADDR_W-1:0] DEF_VECBASE = 32'h4000_0000,
   parameter int                LVL_STRIDE  = 'h40,
   parameter logic [ADDR_W-1:0] KERN_VEC    = 32'h4000_0300,
   parameter logic [ADDR_W-1:0] USER_VEC    = 32'h4000_0340,
   parameter logic [ADDR_W-1:0] DBL_VEC     = 32'h4000_03C0
) (
   input  logic [NLEVEL:1]     lvl_sel,
   input  exc_cls_e            cls,
   input  logic [ADDR_W-1:0]   vecbase,
   input  logic [ADDR_W-1:0]   cur_pc,
   output logic [ADDR_W-1:0]   target
);
   logic [ADDR_W-1:0] lvl_vec [1:NLEVEL];
   logic [ADDR_W-1:0] dflt;
   logic [ADDR_W-1:0] moved;

   for (genvar i = 1; i <= NLEVEL; i++) begin : g_vec
      assign lvl_vec[i] = DEF_VECBASE + ADDR_W'(i * LVL_STRIDE);
   end

   always_comb begin
      dflt = '0;
      unique case (cls)
         CLS_HILVL: begin
            for (int i = 1; i <= NLEVEL; i++) begin
               if (lvl_sel[i]) dflt = lvl_vec[i];
            end
         end
         CLS_KERNEL: dflt = KERN_VEC;
         CLS_USER:   dflt = USER_VEC;
         default:    dflt = DBL_VEC;
      endcase
   end

   if (RELOC_EN) begin : g_reloc
      assign moved = dflt - DEF_VECBASE + vecbase;
   end else begin : g_fixed
      logic unused_vb;
      assign unused_vb = ^vecbase;
      assign moved     = dflt;
   end

   assign target = (dflt == '0) ? cur_pc : moved;
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
   import irq_disp_pkg::*;
#(
   parameter int                NLEVEL      = 7,
   parameter int                ADDR_W      = 32,
   parameter int                INT_W       = 32,
   parameter bit                HAS_DEPC    = 1'b1,
   parameter bit                RELOC_EN    = 1'b1,
   parameter logic [ADDR_W-1:0] DEF_VECBASE = 32'h4000_0000,
   parameter int                LVL_STRIDE  = 'h40,
   parameter logic [ADDR_W-1:0] KERN_VEC    = 32'h4000_0300,
   parameter logic [ADDR_W-1:0] USER_VEC    = 32'h4000_0340,
   parameter logic [ADDR_W-1:0] DBL_VEC     = 32'h4000_03C0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     irq_pending,
   input  logic [PS_LVL_W-1:0]      irq_level,
   input  logic [ADDR_W-1:0]        ps_in,
   input  logic [INT_W-1:0]         int_set,
   input  logic [INT_W-1:0]         int_enable,
   input  logic [ADDR_W-1:0]        cur_pc,
   input  logic [ADDR_W-1:0]        vecbase,
   output logic                     taken,
   output logic [ADDR_W-1:0]        next_pc,
   output logic [ADDR_W-1:0]        next_ps,
   output logic [1:0]               exc_class,
   output logic [CAUSE_W-1:0]       exc_cause,
   output logic [NLEVEL*ADDR_W-1:0] epc_flat,
   output logic [NLEVEL*ADDR_W-1:0] eps_flat,
   output logic [ADDR_W-1:0]        depc
);
   localparam int SLOT_W = ADDR_W;

   if (NLEVEL < 2 || NLEVEL > (1 << PS_LVL_W) - 1) begin : g_chk_nlevel
      $error("irq_dispatch: NLEVEL must fit the status level field");
   end
   if (ADDR_W < PS_UM_BIT + 1) begin : g_chk_addr
      $error("irq_dispatch: ADDR_W too narrow for the status word");
   end
   if (INT_W < NLEVEL) begin : g_chk_int
      $error("irq_dispatch: every level needs at least one interrupt line");
   end

   logic [NLEVEL:1]   lvl_sel;
   logic              accept;
   exc_cls_e          cls;
   logic [ADDR_W-1:0] ps_nx;
   logic [ADDR_W-1:0] target;
   logic              to_depc;

   irq_accept #(.NLEVEL(NLEVEL), .INT_W(INT_W), .LVL_W(PS_LVL_W)) u_accept (
      .pending   (irq_pending),
      .lvl       (irq_level),
      .cur_lvl   (ps_in[PS_LVL_W-1:0]),
      .intset    (int_set),
      .intenable (int_enable),
      .lvl_sel   (lvl_sel),
      .accept    (accept)
   );

   always_comb begin
      if (!lvl_sel[1])                cls = CLS_HILVL;
      else if (ps_in[PS_EXCM_BIT])    cls = CLS_DOUBLE;
      else if (ps_in[PS_UM_BIT])      cls = CLS_USER;
      else                            cls = CLS_KERNEL;
   end

   always_comb begin
      ps_nx = ps_in;
      if (cls == CLS_HILVL) ps_nx[PS_LVL_W-1:0] = irq_level;
      ps_nx[PS_EXCM_BIT] = 1'b1;
   end

   assign to_depc = HAS_DEPC && (cls == CLS_DOUBLE);

   irq_vector #(
      .NLEVEL(NLEVEL), .ADDR_W(ADDR_W), .RELOC_EN(RELOC_EN),
      .DEF_VECBASE(DEF_VECBASE), .LVL_STRIDE(LVL_STRIDE),
      .KERN_VEC(KERN_VEC), .USER_VEC(USER_VEC), .DBL_VEC(DBL_VEC)
   ) u_vector (
      .lvl_sel (lvl_sel),
      .cls     (cls),
      .vecbase (vecbase),
      .cur_pc  (cur_pc),
      .target  (target)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         taken     <= 1'b0;
         next_pc   <= '0;
         next_ps   <= '0;
         exc_class <= '0;
         exc_cause <= '0;
      end else begin
         taken <= accept;
         if (accept) begin
            next_pc   <= target;
            next_ps   <= ps_nx;
            exc_class <= cls;
            if (cls != CLS_HILVL) exc_cause <= CAUSE_LVL1_IRQ;
         end
      end
   end

   for (genvar i = 1; i <= NLEVEL; i++) begin : g_save
      logic [ADDR_W-1:0] epc_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                                        epc_q <= '0;
         else if (accept && lvl_sel[i] && !(i == 1 && to_depc)) epc_q <= cur_pc;
      end
      assign epc_flat[(i-1)*SLOT_W +: SLOT_W] = epc_q;

      if (i >= 2) begin : g_eps
         logic [ADDR_W-1:0] eps_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                    eps_q <= '0;
            else if (accept && lvl_sel[i]) eps_q <= ps_in;
         end
         assign eps_flat[(i-1)*SLOT_W +: SLOT_W] = eps_q;
      end else begin : g_no_eps
         assign eps_flat[(i-1)*SLOT_W +: SLOT_W] = '0;
      end
   end

   if (HAS_DEPC) begin : g_depc
      logic [ADDR_W-1:0] depc_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                  depc_q <= '0;
         else if (accept && to_depc)  depc_q <= cur_pc;
      end
      assign depc = depc_q;
   end else begin : g_no_depc
      assign depc = '0;
   end

   assert_accept_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      taken |-> ($past(irq_pending) && ($past(irq_level) > $past(ps_in[PS_LVL_W-1:0]))));

   assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !taken |-> ($stable(next_pc) && $stable(next_ps) && $stable(exc_class)
                  && $stable(epc_flat) && $stable(eps_flat) && $stable(depc)));

   assert_hilvl_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && exc_class == CLS_HILVL) |->
         (next_ps[PS_LVL_W-1:0] == $past(irq_level) && next_ps[PS_EXCM_BIT]));

   assert_lvl1_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && exc_class != CLS_HILVL) |->
         (exc_cause == CAUSE_LVL1_IRQ && next_ps[PS_EXCM_BIT]));

   assert_double_from_excm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && exc_class == CLS_DOUBLE) |-> $past(ps_in[PS_EXCM_BIT]));

   assert_user_kernel_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && (exc_class == CLS_KERNEL || exc_class == CLS_USER)) |->
         (!$past(ps_in[PS_EXCM_BIT]) && ((exc_class == CLS_USER) == $past(ps_in[PS_UM_BIT]))));
endmodule

// File: tb/sim_irq_dispatch.sv
module sim_irq_dispatch;
   localparam int NL = 7;
   localparam logic [31:0] BASE = 32'h4000_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        pend = 1'b0;
   logic [3:0]  lvl = '0;
   logic [31:0] ps = '0, iset = '0, ien = '0, pc = '0, vb = '0;

   logic              taken [2];
   logic [31:0]       npc [2];
   logic [31:0]       nps [2];
   logic [1:0]        cls [2];
   logic [5:0]        cause [2];
   logic [NL*32-1:0]  epcf [2];
   logic [NL*32-1:0]  epsf [2];
   logic [31:0]       depc [2];

   irq_dispatch u0 (
      .clk(clk), .rst_n(rst_n), .irq_pending(pend), .irq_level(lvl), .ps_in(ps),
      .int_set(iset), .int_enable(ien), .cur_pc(pc), .vecbase(vb),
      .taken(taken[0]), .next_pc(npc[0]), .next_ps(nps[0]), .exc_class(cls[0]),
      .exc_cause(cause[0]), .epc_flat(epcf[0]), .eps_flat(epsf[0]), .depc(depc[0]));

   irq_dispatch #(.HAS_DEPC(1'b0), .RELOC_EN(1'b0), .DBL_VEC(32'h0)) u1 (
      .clk(clk), .rst_n(rst_n), .irq_pending(pend), .irq_level(lvl), .ps_in(ps),
      .int_set(iset), .int_enable(ien), .cur_pc(pc), .vecbase(vb),
      .taken(taken[1]), .next_pc(npc[1]), .next_ps(nps[1]), .exc_class(cls[1]),
      .exc_cause(cause[1]), .epc_flat(epcf[1]), .eps_flat(epsf[1]), .depc(depc[1]));

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic        e_taken [2];
   logic [31:0] e_npc [2], e_nps [2], e_depc [2];
   logic [1:0]  e_cls [2];
   logic [5:0]  e_cause [2];
   logic [31:0] e_epc [2][1:NL];
   logic [31:0] e_eps [2][1:NL];
   logic        e_zero [2];

   task automatic chk(input bit ok, input string tag, input int k,
                      input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s u%0d actual=%0h expected=%0h", tag, k, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int k = 0; k < 2; k++) begin
         e_taken[k] = 0; e_npc[k] = 0; e_nps[k] = 0; e_depc[k] = 0;
         e_cls[k] = 0; e_cause[k] = 0; e_zero[k] = 0;
         for (int i = 1; i <= NL; i++) begin e_epc[k][i] = 0; e_eps[k][i] = 0; end
      end
   endtask

   function automatic bit accepted();
      bit hit = 0;
      for (int b = 0; b < 32; b++)
         if (((b % NL) + 1) == int'(lvl) && iset[b] && ien[b]) hit = 1;
      return pend && (lvl > ps[3:0]) && (int'(lvl) <= NL) && hit;
   endfunction

   task automatic model_step(input int k);
      logic [31:0] dv;
      logic [31:0] nxt;
      e_taken[k] = accepted();
      if (!e_taken[k]) return;
      if (lvl > 1) begin
         e_cls[k] = 2'd0;
         e_epc[k][lvl] = pc;
         e_eps[k][lvl] = ps;
         nxt = ps; nxt[3:0] = lvl; nxt[4] = 1'b1;
         e_nps[k] = nxt;
         dv = BASE + 32'(int'(lvl) * 'h40);
      end else begin
         e_cause[k] = 6'd4;
         nxt = ps; nxt[4] = 1'b1;
         e_nps[k] = nxt;
         if (ps[4]) begin
            e_cls[k] = 2'd3;
            if (k == 0) e_depc[k] = pc; else e_epc[k][1] = pc;
            dv = (k == 0) ? 32'h4000_03C0 : 32'h0;
         end else begin
            e_epc[k][1] = pc;
            e_cls[k] = ps[5] ? 2'd2 : 2'd1;
            dv = ps[5] ? 32'h4000_0340 : 32'h4000_0300;
         end
      end
      e_zero[k] = (dv == 0);
      if (dv == 0)     e_npc[k] = pc;
      else if (k == 0) e_npc[k] = dv - BASE + vb;
      else             e_npc[k] = dv;
   endtask

   task automatic compare(input int k, input bit in_reset);
      logic [NL*32-1:0] fe, fs;
      string t_pc, t_ps, t_cls, t_sv;
      for (int i = 1; i <= NL; i++) begin
         fe[(i-1)*32 +: 32] = e_epc[k][i];
         fs[(i-1)*32 +: 32] = e_eps[k][i];
      end
      if (in_reset) begin
         t_pc = "R10"; t_ps = "R10"; t_cls = "R10"; t_sv = "R10";
      end else if (!e_taken[k]) begin
         t_pc = "R2"; t_ps = "R2"; t_cls = "R2"; t_sv = "R2";
      end else if (e_cls[k] == 2'd0) begin
         t_pc = (k == 0) ? "R8" : "R4"; t_ps = "R3"; t_cls = "R3"; t_sv = "R3";
      end else begin
         t_pc = e_zero[k] ? "R9" : ((k == 0) ? "R8" : "R7");
         t_ps = "R5";
         t_cls = (e_cls[k] == 2'd3) ? "R6" : "R7";
         t_sv = t_cls;
      end
      chk(taken[k] == e_taken[k], in_reset ? "R10" : "R1", k, 256'(taken[k]), 256'(e_taken[k]));
      chk(npc[k] == e_npc[k], t_pc, k, 256'(npc[k]), 256'(e_npc[k]));
      chk(nps[k] == e_nps[k], t_ps, k, 256'(nps[k]), 256'(e_nps[k]));
      chk(cls[k] == e_cls[k], t_cls, k, 256'(cls[k]), 256'(e_cls[k]));
      chk(cause[k] == e_cause[k], in_reset ? "R10" : "R5", k, 256'(cause[k]), 256'(e_cause[k]));
      chk(epcf[k] == fe, t_sv, k, 256'(epcf[k]), 256'(fe));
      chk(epsf[k] == fs, t_sv, k, 256'(epsf[k]), 256'(fs));
      chk(depc[k] == e_depc[k], t_sv, k, 256'(depc[k]), 256'(e_depc[k]));
   endtask

   task automatic step(input logic p, input logic [3:0] l, input logic [31:0] s,
                       input logic [31:0] st, input logic [31:0] en,
                       input logic [31:0] c, input logic [31:0] v);
      @(negedge clk);
      pend = p; lvl = l; ps = s; iset = st; ien = en; pc = c; vb = v;
      for (int k = 0; k < 2; k++) model_step(k);
      @(posedge clk);
      #1;
      for (int k = 0; k < 2; k++) compare(k, 1'b0);
   endtask

   initial begin
      int cyc = 0;
      while (!done && cyc < 50000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      // R10: outputs zero while in reset
      for (int k = 0; k < 2; k++) compare(k, 1'b1);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: level equal to current level is refused
      step(1, 4'd3, 32'h3, '1, '1, 32'h100, 32'h8000_0000);
      // R1: level above NLEVEL is refused
      step(1, 4'd8, 32'h0, '1, '1, 32'h104, 32'h8000_0000);
      // R1: level 0 is refused
      step(1, 4'd0, 32'h0, '1, '1, 32'h108, 32'h8000_0000);
      // R1: no enabled line of that level
      step(1, 4'd3, 32'h0, '1, 32'h0, 32'h10C, 32'h8000_0000);
      // R1: enabled line of another level only (bit 0 is level 1)
      step(1, 4'd3, 32'h0, '1, 32'h1, 32'h110, 32'h8000_0000);
      // R2: request strobe low is ignored
      step(0, 4'd5, 32'h0, '1, '1, 32'h114, 32'h8000_0000);
      // R3 R4 R8: every high level
      for (int l = 2; l <= NL; l++)
         step(1, 4'(l), 32'hA5A5_0020 | 32'(l - 1), '1, '1, 32'h2000 + 32'(l), 32'h9000_0000);
      // R7: level 1 kernel then user
      step(1, 4'd1, 32'h0000_0000, '1, '1, 32'h3000, 32'h9000_0000);
      step(1, 4'd1, 32'h0000_0020, '1, '1, 32'h3004, 32'h9000_0000);
      // R6 R9: level 1 double (u1 has a zero vector)
      step(1, 4'd1, 32'h0000_0010, '1, '1, 32'h3008, 32'h9000_0000);
      // R2: idle cycle after takes
      step(0, 4'd0, 32'h0, '0, '0, 32'h0, 32'h0);

      for (int n = 0; n < 400; n++) begin
         r = $urandom;
         step(r[0] | r[1], 4'($urandom % 9), ($urandom & 32'hFFFF_FFF0) | 32'($urandom % 8),
              $urandom, $urandom & $urandom & $urandom, $urandom, $urandom);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule